// File: doc/BRIEF.md
# Trace Cache Fill and Lookup

This block keeps short runs of already executed instructions so that a fetch stage can obtain several of them in one request. A fill port accepts the executed instruction stream one instruction per cycle. Each instruction comes with its PC, its instruction word, a branch flag, a taken flag and a branch target. The fill logic packs consecutive executed instructions into one trace line and follows taken branches into their targets. One line can therefore span several basic blocks, and it never holds instructions that were skipped. A line is closed when it holds eight instructions or three branches, whichever happens first. It is then written into a direct-mapped store of sixteen lines, tagged with the PC of its first instruction.

A lookup port takes a fetch PC and answers one cycle later. A hit returns the stored instruction words, how many of them are valid, the direction of each branch inside the line, and the PC at which fetch resumes after the line. On a miss the fetch stage falls back to its ordinary path. A flush input empties the whole store in one cycle and throws away any line that is still being built.

The block assumes that the maximum line length and the branch limit are both at least two. Under that assumption one fill cycle never has to write two lines.

Top module: `trace_cache`

## Requirements
- R1: After reset every line is invalid, and every lookup misses.
- R2: A lookup presented with `lk_valid` is answered by `resp_valid` in the next cycle. `resp_hit` is 1 only when the selected line is valid and its stored start PC equals the full lookup PC. A PC that shares the index but differs in its upper bits misses.
- R3: On a miss, `resp_cnt`, `resp_nbr`, `resp_dirs` and `resp_insn` are all zero, and `resp_next_pc` equals the lookup PC.
- R4: A line is written in the cycle its eighth instruction is accepted. Its count is 8. Its resume PC is the last instruction's PC plus 4, or that instruction's target if it is a taken branch. A lookup issued after that cycle hits it.
- R5: A line is written when its third branch is accepted, whatever its length. The resume PC is that branch's target if it was taken, and its PC plus 4 if it was not.
- R6: After a taken branch, the next stored instruction is the one the stream delivers at the target. Slot k of `resp_insn` (bits k*32 up to k*32+31) holds the k-th accepted instruction of the line. Slots at or above the count read zero.
- R7: Bit k of `resp_dirs` holds the taken flag of the k-th branch in the line, and `resp_nbr` gives the number of branches in the line.
- R8: A fill whose PC differs from the resume PC of a non-empty partial line writes that partial line unchanged. The fill then starts a new line tagged with its own PC.
- R9: A flush invalidates all lines and discards the partial line. A fill in the flush cycle is ignored, and a lookup in the flush cycle misses.
- R10: The line index is PC bits 5 down to 2. A newly written line replaces the line previously held at that index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate all lines and drop the partial line |
| fill_valid | input | 1 | An executed instruction is presented |
| fill_pc | input | 32 | PC of the presented instruction |
| fill_insn | input | 32 | Instruction word |
| fill_is_br | input | 1 | Instruction is a branch |
| fill_taken | input | 1 | Branch was taken |
| fill_target | input | 32 | Branch target PC |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | 32 | Fetch PC to look up |
| resp_valid | output | 1 | Lookup answer present |
| resp_hit | output | 1 | Lookup hit |
| resp_insn | output | 256 | Stored instruction words, slot 0 in the low bits |
| resp_cnt | output | 4 | Number of valid instruction slots |
| resp_nbr | output | 2 | Number of branches in the line |
| resp_dirs | output | 3 | Taken flag of each branch in the line |
| resp_next_pc | output | 32 | PC at which fetch resumes after the line |

## Verification
The bench builds lines that close on the length limit and on the branch limit. One line crosses taken branches; a design that stored the fall-through addresses or misordered the slots would return the wrong words or the wrong resume PC. A broken stream checks that the partial line is written as it stood, and an alias at the same index with a different tag must miss; a design that compared only index bits would report a false hit. A flush is issued together with a fill and a lookup, and the store is then refilled from the discarded line's next PC. A design that kept the partial line, or let the flush-cycle fill through, would build a line with the wrong tag or the wrong contents.

// File: rtl/tc_pkg.sv
// Shared constants and the trace line record for the trace cache.
// Assumes MAX_INSN >= 2 and MAX_BR >= 2, so one fill writes at most one line.
package tc_pkg;
    parameter int PC_W     = 32;
    parameter int INSN_W   = 32;
    parameter int MAX_INSN = 8;
    parameter int MAX_BR   = 3;
    parameter int NLINES   = 16;
    parameter int ALIGN    = 2;
    localparam int IDX_W   = $clog2(NLINES);
    localparam int CNT_W   = $clog2(MAX_INSN + 1);
    localparam int SLOT_W  = $clog2(MAX_INSN);
    localparam int BRC_W   = $clog2(MAX_BR + 1);

    typedef struct packed {
        logic [PC_W-1:0]                  tag;
        logic [MAX_INSN-1:0][INSN_W-1:0]  insn;
        logic [CNT_W-1:0]                 cnt;
        logic [BRC_W-1:0]                 nbr;
        logic [MAX_BR-1:0]                dirs;
        logic [PC_W-1:0]                  next_pc;
    } line_t;
endpackage

// File: rtl/tc_fill_builder.sv
// Assembles the executed instruction stream into trace lines.
// Closes a line at MAX_INSN instructions or MAX_BR branches, and writes a
// partial line when the stream breaks away from its resume PC.
// Assumes one instruction per cycle in execution order.
module tc_fill_builder
    import tc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              fill_valid,
    input  logic [PC_W-1:0]   fill_pc,
    input  logic [INSN_W-1:0] fill_insn,
    input  logic              fill_is_br,
    input  logic              fill_taken,
    input  logic [PC_W-1:0]   fill_target,
    output logic              wr_en,
    output line_t             wr_line
);
    line_t cur, nxt, work;
    logic  wr_raw;
    logic  restart;
    logic  close;
    logic [PC_W-1:0] seq_pc;

    // Next-line computation: restart on a break, append, close on limits.
    always_comb begin
        work    = cur;
        nxt     = cur;
        wr_raw  = 1'b0;
        wr_line = cur;
        restart = 1'b0;
        close   = 1'b0;
        seq_pc  = fill_pc + PC_W'(1 << ALIGN);
        if (fill_valid) begin
            restart = (cur.cnt != '0) && (fill_pc != cur.next_pc);
            if (restart) begin
                wr_raw  = 1'b1;
                wr_line = cur;
            end
            if (restart || (cur.cnt == '0)) begin
                work     = '0;
                work.tag = fill_pc;
            end
            work.insn[work.cnt[SLOT_W-1:0]] = fill_insn;
            work.next_pc = (fill_is_br && fill_taken) ? fill_target : seq_pc;
            if (fill_is_br) begin
                work.dirs[work.nbr] = fill_taken;
                work.nbr = work.nbr + 1'b1;
            end
            work.cnt = work.cnt + 1'b1;
            close = (work.cnt == CNT_W'(MAX_INSN)) || (work.nbr == BRC_W'(MAX_BR));
            if (close) begin
                wr_raw  = 1'b1;
                wr_line = work;
                nxt     = '0;
            end else begin
                nxt = work;
            end
        end
    end

    // A flush cancels any write from the same cycle.
    assign wr_en = wr_raw && !flush;

    // Partial line register, emptied by reset and by flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) cur <= '0;
        else                 cur <= nxt;
    end
endmodule

// File: rtl/tc_line_store.sv
// Direct-mapped line storage with one write port and a registered read port.
// A read in a write cycle returns the old contents; a read in a flush cycle
// reports the line invalid.
module tc_line_store
    import tc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr_en,
    input  line_t            wr_line,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output line_t            rd_line,
    output logic             rd_vld
);
    line_t             lines [NLINES];
    logic [NLINES-1:0] valid;
    logic [IDX_W-1:0]  wr_idx;

    assign wr_idx = wr_line.tag[ALIGN +: IDX_W];

    // Valid bits: cleared by reset or flush, set by a line write.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) valid <= '0;
        else if (wr_en)      valid[wr_idx] <= 1'b1;
    end

    // Line contents: written on close, no reset needed behind valid.
    always_ff @(posedge clk) begin
        if (wr_en) lines[wr_idx] <= wr_line;
    end

    // Registered read of the indexed line and its valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_line <= '0;
            rd_vld  <= 1'b0;
        end else if (rd_en) begin
            rd_line <= lines[rd_idx];
            rd_vld  <= valid[rd_idx] && !flush;
        end
    end
endmodule

// File: rtl/tc_hit_logic.sv
// Full-tag compare and response shaping; a miss returns zeros and echoes the PC.
module tc_hit_logic
    import tc_pkg::*;
(
    input  logic                       req_q,
    input  logic [PC_W-1:0]            pc_q,
    input  line_t                      line,
    input  logic                       line_vld,
    output logic                       resp_valid,
    output logic                       resp_hit,
    output logic [MAX_INSN*INSN_W-1:0] resp_insn,
    output logic [CNT_W-1:0]           resp_cnt,
    output logic [BRC_W-1:0]           resp_nbr,
    output logic [MAX_BR-1:0]          resp_dirs,
    output logic [PC_W-1:0]            resp_next_pc
);
    logic hit;

    // Tag compare and gating of the line fields.
    always_comb begin
        hit          = req_q && line_vld && (line.tag == pc_q);
        resp_valid   = req_q;
        resp_hit     = hit;
        resp_insn    = hit ? line.insn : '0;
        resp_cnt     = hit ? line.cnt  : '0;
        resp_nbr     = hit ? line.nbr  : '0;
        resp_dirs    = hit ? line.dirs : '0;
        resp_next_pc = hit ? line.next_pc : pc_q;
    end
endmodule

// File: rtl/trace_cache.sv
// Trace cache top: fill builder, line store and lookup compare.
// Lookups answer one cycle after the request.
module trace_cache
    import tc_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       fill_valid,
    input  logic [PC_W-1:0]            fill_pc,
    input  logic [INSN_W-1:0]          fill_insn,
    input  logic                       fill_is_br,
    input  logic                       fill_taken,
    input  logic [PC_W-1:0]            fill_target,
    input  logic                       lk_valid,
    input  logic [PC_W-1:0]            lk_pc,
    output logic                       resp_valid,
    output logic                       resp_hit,
    output logic [MAX_INSN*INSN_W-1:0] resp_insn,
    output logic [CNT_W-1:0]           resp_cnt,
    output logic [BRC_W-1:0]           resp_nbr,
    output logic [MAX_BR-1:0]          resp_dirs,
    output logic [PC_W-1:0]            resp_next_pc
);
    logic            wr_en;
    line_t           wr_line;
    line_t           rd_line;
    logic            rd_vld;
    logic            req_q;
    logic [PC_W-1:0] pc_q;

    tc_fill_builder u_fill (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .fill_valid(fill_valid), .fill_pc(fill_pc), .fill_insn(fill_insn),
        .fill_is_br(fill_is_br), .fill_taken(fill_taken), .fill_target(fill_target),
        .wr_en(wr_en), .wr_line(wr_line)
    );

    tc_line_store u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .wr_en(wr_en), .wr_line(wr_line),
        .rd_en(lk_valid), .rd_idx(lk_pc[ALIGN +: IDX_W]),
        .rd_line(rd_line), .rd_vld(rd_vld)
    );

    // Request and PC held for the compare stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            pc_q  <= '0;
        end else begin
            req_q <= lk_valid;
            if (lk_valid) pc_q <= lk_pc;
        end
    end

    tc_hit_logic u_hit (
        .req_q(req_q), .pc_q(pc_q), .line(rd_line), .line_vld(rd_vld),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_insn(resp_insn),
        .resp_cnt(resp_cnt), .resp_nbr(resp_nbr), .resp_dirs(resp_dirs),
        .resp_next_pc(resp_next_pc)
    );
endmodule

// File: rtl/tc_checker.sv
// Port-level properties of the trace cache, bound to every instance.
module tc_checker
    import tc_pkg::*;
(
    input logic                       clk,
    input logic                       rst_n,
    input logic                       flush,
    input logic                       fill_valid,
    input logic [PC_W-1:0]            fill_pc,
    input logic [INSN_W-1:0]          fill_insn,
    input logic                       fill_is_br,
    input logic                       fill_taken,
    input logic [PC_W-1:0]            fill_target,
    input logic                       lk_valid,
    input logic [PC_W-1:0]            lk_pc,
    input logic                       resp_valid,
    input logic                       resp_hit,
    input logic [MAX_INSN*INSN_W-1:0] resp_insn,
    input logic [CNT_W-1:0]           resp_cnt,
    input logic [BRC_W-1:0]           resp_nbr,
    input logic [MAX_BR-1:0]          resp_dirs,
    input logic [PC_W-1:0]            resp_next_pc
);
    // R2: every request is answered in the next cycle
    a_r2_answer_next: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> resp_valid);
    // R2: no answer without a request
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !resp_valid);
    // R3: a miss echoes the lookup PC and carries no line data
    a_r3_miss_empty: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (resp_hit || (resp_cnt == '0 && resp_nbr == '0 &&
                      resp_dirs == '0 && resp_insn == '0 &&
                      resp_next_pc == $past(lk_pc))));
    // R4: a hit line holds between one and MAX_INSN instructions
    a_r4_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        resp_hit |-> (resp_cnt != '0 && resp_cnt <= CNT_W'(MAX_INSN)));
    // R7: taken flags never outnumber recorded branches
    a_r7_dirs_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        resp_hit |-> ($countones(resp_dirs) <= int'(resp_nbr) &&
                      resp_nbr <= BRC_W'(MAX_BR)));
    // R9: a lookup in a flush cycle misses
    a_r9_flush_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && lk_valid) |=> !resp_hit);
endmodule

bind trace_cache tc_checker u_chk (.*);

// File: tb/tb_trace_cache.sv
// Scoreboard bench: lookups push expected answers, a monitor compares them.
module tb_trace_cache;
    import tc_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic fill_valid = 1'b0;
    logic [31:0] fill_pc = '0, fill_insn = '0, fill_target = '0;
    logic fill_is_br = 1'b0, fill_taken = 1'b0;
    logic lk_valid = 1'b0;
    logic [31:0] lk_pc = '0;
    logic resp_valid, resp_hit;
    logic [255:0] resp_insn;
    logic [3:0] resp_cnt;
    logic [1:0] resp_nbr;
    logic [2:0] resp_dirs;
    logic [31:0] resp_next_pc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic         hit;
        logic [3:0]   cnt;
        logic [1:0]   nbr;
        logic [2:0]   dirs;
        logic [31:0]  nxt;
        logic [255:0] insn;
    } exp_t;
    exp_t  exq[$];
    string tagq[$];
    logic [31:0] ep [8];

    always #4 clk = ~clk;

    trace_cache dut (.*);

    function automatic logic [31:0] mkins(input logic [31:0] pc);
        return {8'hC0, pc[23:0]};
    endfunction

    task automatic chk(input string rq, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // Monitor: pops one expectation per answered lookup.
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (exq.size() == 0) begin
                chk("R2", "unexpected answer", 256'(1), 256'(0));
            end else begin
                automatic exp_t  e = exq.pop_front();
                automatic string t = tagq.pop_front();
                chk(t, "hit",  256'(resp_hit), 256'(e.hit));
                chk(t, "cnt",  256'(resp_cnt), 256'(e.cnt));
                chk(t, "nbr",  256'(resp_nbr), 256'(e.nbr));
                chk(t, "dirs", 256'(resp_dirs), 256'(e.dirs));
                chk(t, "next", 256'(resp_next_pc), 256'(e.nxt));
                chk(t, "insn", resp_insn, e.insn);
            end
        end
    end

    task automatic fill(input logic [31:0] pc, input bit br, input bit tk,
                        input logic [31:0] tgt);
        fill_valid = 1'b1; fill_pc = pc; fill_insn = mkins(pc);
        fill_is_br = br; fill_taken = tk; fill_target = tgt;
        @(posedge clk); #1;
        fill_valid = 1'b0; fill_is_br = 1'b0; fill_taken = 1'b0;
    endtask

    function automatic exp_t make_exp(input logic [31:0] pc, input bit hit,
                                      input int cnt, input int nbr,
                                      input logic [2:0] dirs, input logic [31:0] nxt);
        exp_t e;
        e.hit = hit; e.insn = '0;
        if (hit) begin
            e.cnt = 4'(cnt); e.nbr = 2'(nbr); e.dirs = dirs; e.nxt = nxt;
            for (int k = 0; k < cnt; k++) e.insn[k*32 +: 32] = mkins(ep[k]);
        end else begin
            e.cnt = '0; e.nbr = '0; e.dirs = '0; e.nxt = pc;
        end
        return e;
    endfunction

    task automatic look(input string rq, input logic [31:0] pc, input bit hit,
                        input int cnt, input int nbr, input logic [2:0] dirs,
                        input logic [31:0] nxt);
        exq.push_back(make_exp(pc, hit, cnt, nbr, dirs, nxt));
        tagq.push_back(rq);
        lk_valid = 1'b1; lk_pc = pc;
        @(posedge clk); #1;
        lk_valid = 1'b0;
    endtask

    task automatic miss(input string rq, input logic [31:0] pc);
        look(rq, pc, 1'b0, 0, 0, 3'b000, 32'h0);
    endtask

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R1: empty after reset
        miss("R1", 32'h0000_1000);

        // R4: eight sequential instructions close the line
        for (int k = 0; k < 8; k++) begin
            ep[k] = 32'h1000 + 32'(k * 4);
            fill(ep[k], 1'b0, 1'b0, 32'h0);
        end
        look("R4", 32'h1000, 1'b1, 8, 0, 3'b000, 32'h1020);

        // R5 R6 R7: path across taken branches closes on the third branch
        ep[0] = 32'h2044; ep[1] = 32'h2048; ep[2] = 32'h3000;
        ep[3] = 32'h3004; ep[4] = 32'h3008;
        fill(32'h2044, 1'b0, 1'b0, 32'h0);
        fill(32'h2048, 1'b1, 1'b1, 32'h3000);
        fill(32'h3000, 1'b0, 1'b0, 32'h0);
        fill(32'h3004, 1'b1, 1'b0, 32'h5555);
        fill(32'h3008, 1'b1, 1'b1, 32'h4010);
        look("R6", 32'h2044, 1'b1, 5, 3, 3'b101, 32'h4010);

        // R8: a break in the stream writes the partial line as it stood
        ep[0] = 32'h5008; ep[1] = 32'h500C;
        fill(32'h5008, 1'b0, 1'b0, 32'h0);
        fill(32'h500C, 1'b0, 1'b0, 32'h0);
        fill(32'h600C, 1'b0, 1'b0, 32'h0);
        fill(32'h6010, 1'b0, 1'b0, 32'h0);
        look("R8", 32'h5008, 1'b1, 2, 0, 3'b000, 32'h5010);
        miss("R8", 32'h600C);

        // R2: same index, different upper bits
        miss("R2", 32'h1040);
        // R3: miss fields on an unknown PC
        miss("R3", 32'h0ABC_0010);

        // R9: flush with a fill and a lookup in the same cycle
        exq.push_back(make_exp(32'h1000, 1'b0, 0, 0, 3'b000, 32'h0));
        tagq.push_back("R9");
        flush = 1'b1; lk_valid = 1'b1; lk_pc = 32'h1000;
        fill_valid = 1'b1; fill_pc = 32'h6014; fill_insn = 32'hDEAD_BEEF;
        @(posedge clk); #1;
        flush = 1'b0; lk_valid = 1'b0; fill_valid = 1'b0;
        miss("R9", 32'h1000);
        miss("R9", 32'h2044);
        miss("R9", 32'h5008);
        for (int k = 0; k < 8; k++) begin
            ep[k] = 32'h6014 + 32'(k * 4);
            fill(ep[k], 1'b0, 1'b0, 32'h0);
        end
        miss("R9", 32'h600C);
        look("R9", 32'h6014, 1'b1, 8, 0, 3'b000, 32'h6034);

        // R10 R5: two lines at index 0, the later replaces the earlier
        fill(32'h8000, 1'b1, 1'b0, 32'h0);
        fill(32'h8004, 1'b1, 1'b0, 32'h0);
        fill(32'h8008, 1'b1, 1'b0, 32'h0);
        ep[0] = 32'h8000; ep[1] = 32'h8004; ep[2] = 32'h8008;
        look("R5", 32'h8000, 1'b1, 3, 3, 3'b000, 32'h800C);
        fill(32'h9000, 1'b1, 1'b1, 32'h9100);
        fill(32'h9100, 1'b1, 1'b1, 32'h9200);
        fill(32'h9200, 1'b1, 1'b1, 32'h9300);
        miss("R10", 32'h8000);
        ep[0] = 32'h9000; ep[1] = 32'h9100; ep[2] = 32'h9200;
        look("R10", 32'h9000, 1'b1, 3, 3, 3'b111, 32'h9300);

        repeat (3) @(posedge clk);
        #1;
        if (exq.size() != 0) chk("R2", "unanswered lookups", 256'(exq.size()), 256'(0));
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule